// File: doc/BRIEF.md
# Stereo Audio Frame Serializer (controller transmit)

This block is the transmit half of an audio serial port that acts as the bus controller. The master clock drives the block's clock input. A programmable divider turns that clock into the bit clock (SCK). A slot counter derives the frame clock (LRCK) from SCK. A stereo pair of samples is shifted out MSB first on one data line, with left and right in alternate half-frames. Two framing conventions are available. The standard I2S convention delays the data by one bit and sends the left channel while LRCK is low. The aligned convention sends the left channel while LRCK is high and places the sample at one edge of the half-frame.

The sample width is 8, 16, 24 or 32 bits. The half-frame width (slots per channel) is a separate setting and may be larger than the sample. Slots that the sample does not fill are sent as zeros. Sample pairs arrive through a valid/ready handshake, one pair per frame. If no pair is offered when a frame starts, the previous pair is sent again and an underrun flag is raised for that frame.

A three-state sequencer controls the frame. After reset it sits in ST_START until the first falling SCK edge. That edge takes transition START_TO_LEFT, which loads a pair and opens slot 0. ST_LEFT takes LEFT_TO_RIGHT on the falling edge that enters slot H, where H is the half-frame width. ST_RIGHT takes RIGHT_TO_LEFT on the falling edge that leaves the last slot 2H-1. That transition is the frame boundary, and a new pair is loaded on it. Configuration is expected to stay constant while the block is out of reset.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset, SCK is low. SCK toggles every cfg_div+1 clock cycles, and its first transition is rising.
- R2: LRCK and SDOUT change only on the clock edge where SCK falls. With cfg_fmt=0 (I2S), LRCK is low during left slots 0..H-1 and high during right slots H..2H-1. With cfg_fmt=1 (aligned), LRCK is high for the left half and low for the right half.
- R3: In I2S framing, each sample's MSB is sent in the slot after the LRCK edge. The bit sent in slot 0 of a frame is the bit that belongs to the last slot of the previous frame, which is the right LSB when H equals the sample width, and zero for the first frame.
- R4: In aligned framing with cfg_rjust=0, the sample MSB is in slot 0 of its half and the bits follow MSB first.
- R5: In aligned framing with cfg_rjust=1, the sample starts at slot H-W of its half, so that its LSB is in the last slot.
- R6: Every slot not covered by sample bits is sent as 0.
- R7: cfg_wsel selects the width W as 0=8, 1=16, 2=24, 3=32. The sample is taken from the low W bits of in_left and in_right. in_ready is high for exactly the one clock cycle that ends with the falling SCK edge opening each frame. A pair is accepted when in_valid is high in that cycle.
- R8: If in_valid is low at a frame opening, the previous pair is sent again (zeros before any pair has been accepted) and underrun goes high for that frame. underrun changes only at frame openings.
- R9: While reset is held, and until the first falling SCK edge, SCK, LRCK, SDOUT, underrun and in_ready are all low.
- R10: In I2S framing, cfg_rjust has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | SCK half-period in clocks, minus one |
| cfg_fmt | input | 1 | 0 = I2S framing, 1 = aligned framing |
| cfg_rjust | input | 1 | Aligned framing: 1 = right-justify, 0 = left-justify |
| cfg_wsel | input | 2 | Sample width select (8/16/24/32) |
| cfg_hlen | input | HLEN_W | Slots per half-frame, from W to 2^HLEN_W-1 |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | Frame opening: the pair is taken on this cycle |
| in_left | input | SMP_W | Left sample, low W bits used |
| in_right | input | SMP_W | Right sample, low W bits used |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock |
| sdout | output | 1 | Serial data |
| underrun | output | 1 | The current frame repeats the previous pair |

## Verification
SCK, LRCK, SDOUT and underrun come straight from registers, so each one changes on the clock edge where the divider count completes. in_ready depends only on registered state and is high during the cycle before the edge that opens a frame. The bench's reference model counts clock edges since reset release and derives from that count the number of SCK toggles, the number of falling edges, and the current slot and frame. It also predicts in_ready for the coming edge. All outputs are compared against the model at every falling clock edge, half a period away from the edge where they change. That timing catches a result that arrives one cycle early or late.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } seq_state_t;

    // width select code to sample bits: 0->8, 1->16, 2->24, 3->32
    function automatic int unsigned sample_bits(input logic [1:0] sel);
        return 8 * (int'(sel) + 1);
    endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             fall_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             tick;

    assign tick      = (cnt_q == div);
    assign fall_tick = tick & sck_q;
    assign sck       = sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/aud_ser_bitsel.sv
module aud_ser_bitsel
    import aud_ser_pkg::*;
#(
    parameter int SMP_W  = 32,
    parameter int HLEN_W = 7
) (
    input  logic              fmt_aligned,
    input  logic              rjust,
    input  logic [1:0]        wsel,
    input  logic [HLEN_W-1:0] hlen,
    input  logic [HLEN_W:0]   slot,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic [SMP_W-1:0]  smp_r,
    input  logic              lsb_hold,
    output logic              lr_lvl,
    output logic              dbit
);

    localparam int IW    = HLEN_W + 1;
    localparam int IDX_W = $clog2(SMP_W);

    logic [IW-1:0]    w, h, two_h, q, k, off, pos;
    logic [IDX_W-1:0] idx;
    logic             wrap, second;
    logic [SMP_W-1:0] word;

    always_comb begin
        w      = IW'(sample_bits(wsel));
        h      = {1'b0, hlen};
        two_h  = h << 1;
        // I2S: data lags LRCK by one slot, slot 0 carries the previous frame's last bit
        wrap   = !fmt_aligned && (slot == '0);
        if (fmt_aligned)  q = slot;
        else if (wrap)    q = two_h - 1'b1;
        else              q = slot - 1'b1;
        second = (q >= h);
        k      = second ? (q - h) : q;
        off    = (fmt_aligned && rjust) ? (h - w) : '0;
        word   = second ? smp_r : smp_l;
        pos    = k - off;
        idx    = IDX_W'(w - 1'b1 - pos);
        if (wrap)
            dbit = (h == w) ? lsb_hold : 1'b0;
        else if ((k >= off) && (pos < w))
            dbit = word[idx];
        else
            dbit = 1'b0;
        lr_lvl = fmt_aligned ? (slot < h) : (slot >= h);
    end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HLEN_W = 7,
    parameter int SMP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_fmt,
    input  logic              cfg_rjust,
    input  logic [1:0]        cfg_wsel,
    input  logic [HLEN_W-1:0] cfg_hlen,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SMP_W-1:0]  in_left,
    input  logic [SMP_W-1:0]  in_right,
    output logic              sck,
    output logic              lrck,
    output logic              sdout,
    output logic              underrun
);

    localparam int IW = HLEN_W + 1;

    seq_state_t       st_q, st_nxt;
    logic [IW-1:0]    slot_q, slot_nxt, two_h;
    logic             fall_tick, boundary, load;
    logic [SMP_W-1:0] smp_l_q, smp_r_q, smp_l_nxt, smp_r_nxt;
    logic             lsb_q, lsb_nxt;
    logic             lr_lvl, dbit;
    logic             lrck_q, sdout_q, under_q;

    aud_ser_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (cfg_div),
        .sck       (sck),
        .fall_tick (fall_tick)
    );

    assign two_h = {1'b0, cfg_hlen} << 1;

    // sequencer: next state and slot
    always_comb begin
        st_nxt   = st_q;
        slot_nxt = slot_q;
        boundary = 1'b0;
        unique case (st_q)
            ST_START: if (fall_tick) begin          // START_TO_LEFT
                boundary = 1'b1;
                slot_nxt = '0;
                st_nxt   = ST_LEFT;
            end
            ST_LEFT: if (fall_tick) begin
                slot_nxt = slot_q + 1'b1;
                if (slot_nxt == {1'b0, cfg_hlen})   // LEFT_TO_RIGHT
                    st_nxt = ST_RIGHT;
            end
            ST_RIGHT: if (fall_tick) begin
                if (slot_q == two_h - 1'b1) begin   // RIGHT_TO_LEFT
                    boundary = 1'b1;
                    slot_nxt = '0;
                    st_nxt   = ST_LEFT;
                end else begin
                    slot_nxt = slot_q + 1'b1;
                end
            end
            default: st_nxt = ST_START;
        endcase
    end

    assign in_ready  = boundary;
    assign load      = boundary & in_valid;
    assign smp_l_nxt = load ? in_left  : smp_l_q;
    assign smp_r_nxt = load ? in_right : smp_r_q;
    assign lsb_nxt   = boundary ? smp_r_q[0] : lsb_q;

    aud_ser_bitsel #(.SMP_W(SMP_W), .HLEN_W(HLEN_W)) u_bitsel (
        .fmt_aligned (cfg_fmt),
        .rjust       (cfg_rjust),
        .wsel        (cfg_wsel),
        .hlen        (cfg_hlen),
        .slot        (slot_nxt),
        .smp_l       (smp_l_nxt),
        .smp_r       (smp_r_nxt),
        .lsb_hold    (lsb_nxt),
        .lr_lvl      (lr_lvl),
        .dbit        (dbit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_START;
        else        st_q <= st_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            smp_l_q <= '0;
            smp_r_q <= '0;
            lsb_q   <= 1'b0;
            lrck_q  <= 1'b0;
            sdout_q <= 1'b0;
            under_q <= 1'b0;
        end else if (fall_tick) begin
            slot_q  <= slot_nxt;
            smp_l_q <= smp_l_nxt;
            smp_r_q <= smp_r_nxt;
            lsb_q   <= lsb_nxt;
            lrck_q  <= lr_lvl;
            sdout_q <= dbit;
            if (boundary) under_q <= !in_valid;
        end
    end

    assign lrck     = lrck_q;
    assign sdout    = sdout_q;
    assign underrun = under_q;

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic lrck,
    input logic sdout,
    input logic in_valid,
    input logic in_ready,
    input logic underrun
);

    // R2: frame clock and data move only with a falling bit clock
    assert_move_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lrck) || !$stable(sdout)) |-> $fell(sck));

    // R7: a frame opening is always the cycle before a falling SCK edge
    assert_ready_sck_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> sck);

    // R8: missing pair raises the flag
    assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);

    // R8: accepted pair clears the flag
    assert_underrun_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> !underrun);

    // R8: flag holds between frame openings
    assert_underrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(underrun));

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .lrck     (lrck),
    .sdout    (sdout),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .underrun (underrun)
);

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_div;
    logic        cfg_fmt, cfg_rjust;
    logic [1:0]  cfg_wsel;
    logic [6:0]  cfg_hlen;
    logic        in_valid, in_ready;
    logic [31:0] in_left, in_right;
    logic        sck, lrck, sdout, underrun;

    always #2 clk = ~clk;

    aud_ser_tx u_aud_ser_tx (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fmt(cfg_fmt),
        .cfg_rjust(cfg_rjust), .cfg_wsel(cfg_wsel), .cfg_hlen(cfg_hlen),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
        .in_right(in_right), .sck(sck), .lrck(lrck), .sdout(sdout),
        .underrun(underrun)
    );

    int vectors = 0, errors = 0, n = 0, cyc = 0;
    int D, H, W;
    bit alig, rj;
    logic [31:0] fl [0:63];
    logic [31:0] frr[0:63];
    bit          un [0:63];

    task automatic chk(string tag, logic act, logic exp, string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at edge %0d", tag, what, act, exp, n);
        end
    endtask

    function automatic logic halfbit(logic [31:0] s, int k, output bit pad);
        int pos;
        pos = (alig && rj) ? k - (H - W) : k;
        if (pos < 0 || pos >= W) begin pad = 1; return 1'b0; end
        pad = 0;
        return s[W-1-pos];
    endfunction

    function automatic logic rawbit(int fr, int j, output bit pad);
        if (j < H) return halfbit(fl[fr], j, pad);
        return halfbit(frr[fr], j - H, pad);
    endfunction

    function automatic logic expbit(int fr, int p, output bit pad);
        if (alig) return rawbit(fr, p, pad);
        if (p == 0) begin
            if (fr == 0) begin pad = 1; return 1'b0; end
            return rawbit(fr - 1, 2*H - 1, pad);
        end
        return rawbit(fr, p - 1, pad);
    endfunction

    task automatic check_now(output bit rdy, output int bidx);
        int T, F, s, fr, p, T1;
        bit pad;
        logic eb;
        string tg;
        T = n / D;
        F = T / 2;
        chk("R1", sck, logic'(T[0]), "sck");
        if (F == 0) begin
            chk("R9", lrck, 1'b0, "lrck");
            chk("R9", sdout, 1'b0, "sdout");
            chk("R9", underrun, 1'b0, "underrun");
        end else begin
            s  = F - 1;
            fr = s / (2*H);
            p  = s % (2*H);
            chk("R2", lrck, alig ? (p < H) : (p >= H), "lrck");
            eb = expbit(fr, p, pad);
            if (pad)       tg = "R6";
            else if (!alig) tg = rj ? "R10" : "R3";
            else           tg = rj ? "R5" : "R4";
            chk(tg, sdout, eb, "sdout");
            chk("R8", underrun, logic'(un[fr]), "underrun");
        end
        T1   = (n + 1) / D;
        rdy  = ((n + 1) % D == 0) && (T1 >= 2) && (T1 % 2 == 0) && (((T1/2 - 1) % (2*H)) == 0);
        bidx = rdy ? (T1/2 - 1) / (2*H) : 0;
        chk("R7", in_ready, logic'(rdy), "in_ready");
    endtask

    task automatic run(bit a, bit r, int ws, int hl, int dv, int nfr);
        bit rdy, offer;
        int b;
        alig = a; rj = r; W = 8 * (ws + 1); H = hl; D = dv + 1;
        cfg_fmt = a; cfg_rjust = r; cfg_wsel = 2'(ws); cfg_hlen = 7'(hl); cfg_div = 8'(dv);
        in_valid = 1'b0; in_left = '0; in_right = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", sck, 1'b0, "sck in reset");
        chk("R9", lrck, 1'b0, "lrck in reset");
        chk("R9", sdout, 1'b0, "sdout in reset");
        chk("R9", underrun, 1'b0, "underrun in reset");
        chk("R9", in_ready, 1'b0, "in_ready in reset");
        rst_n = 1'b1;
        n = 0;
        while (1) begin
            check_now(rdy, b);
            if (rdy) begin
                if (b >= nfr) break;
                offer = !(b == 2 || b == 4);
                in_valid = offer;
                in_left  = $urandom;
                in_right = $urandom;
                fl[b]  = offer ? in_left  : (b == 0 ? 32'h0 : fl[b-1]);
                frr[b] = offer ? in_right : (b == 0 ? 32'h0 : frr[b-1]);
                un[b]  = !offer;
            end else begin
                in_valid = 1'b0;
                in_left  = $urandom;
                in_right = $urandom;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        run(1'b0, 1'b0, 1, 16, 0, 7);   // R3 I2S, half-frame equals width, LSB wrap
        run(1'b0, 1'b0, 0, 12, 1, 7);   // R3 R6 I2S with padding
        run(1'b1, 1'b0, 2, 32, 0, 7);   // R4 aligned left with padding
        run(1'b1, 1'b1, 0, 16, 2, 7);   // R5 aligned right
        run(1'b1, 1'b1, 3, 32, 1, 7);   // R5 aligned right, no padding
        run(1'b0, 1'b1, 2, 32, 0, 7);   // R10 right-justify ignored in I2S
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule